// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a byte-wide synchronous serial port. It acts as either the clock-driving master or the clock-following slave of an SPI link. Each transfer moves eight bits out on the data-out pin while eight bits come in on the data-in pin. Bits go most significant first. A CPU writes the outgoing byte into a buffer and reads the incoming byte from the same buffer address. A single 4-bit mode field picks the role and, for a master, the clock source. Three configuration bits set the clock idle level, the clock phase and, for a master, where in the data time the input is sampled.

In master mode a write to the buffer starts a transfer. The shift clock comes from the system clock divided by one of three parameter ratios, or from an external timer pulse divided by two. In slave mode the port follows an external clock that it synchronises internally. An optional active-low select input can gate the port. Three status flags report the transfer state: buffer full, write collision and receive overflow. A one-cycle pulse marks each completed byte.

Top module: `spi_port`

## Requirements
- R1: A transfer exchanges 8 bits in both directions, most significant bit first. At completion the received byte appears on `bufRdData`.
- R2: `modeSel` encodes the mode as follows. 0 is master with an SCK period of `DIV_FAST` clocks (default 4). 1 is master with `DIV_MID` clocks (default 16). 2 is master with `DIV_SLOW` clocks (default 64). 3 is master with one SCK half period per `timerPulse`. 4 is slave with the select input honoured. 5 is slave with the select input ignored. Any other value leaves the port inactive: writes start nothing, and neither `sckOutEn` nor `sdoOutEn` is asserted.
- R3: In a divided-clock master mode, `bufFull` goes high 17 SCK half periods after the clock edge that accepts the write. The divider restarts at each new transfer.
- R4: All four combinations of `clkIdleHigh` and `clkPhase` work. In master mode `sckOut` rests at the `clkIdleHigh` level whenever no transfer is running.
- R5: In master mode with `clkPhase`=0, the input is sampled on the leading SCK edge, or on the trailing edge when `sampleLate`=1. With `clkPhase`=1, it is sampled on the trailing edge, or on the next leading edge (or the end of the byte) when `sampleLate`=1.
- R6: In slave mode, bit 7 of the written byte is on `sdoOut` before the first SCK edge. The remaining bits follow on the shift edges set by `clkPhase`.
- R7: In mode 4, while `ssN` is high `sdoOutEn` is 0. Raising `ssN` mid-byte clears the bit count and reloads the last written byte for the next transfer.
- R8: In mode 5, transfers complete with `ssN` held high, and `sdoOutEn` stays 1.
- R9: `bufFull` and a one-cycle `xferDone` pulse rise when a received byte enters the buffer. A `bufRdEn` pulse clears `bufFull`.
- R10: A write while a transfer is busy sets `writeCollision`. The written data is discarded and the running transfer continues unchanged.
- R11: A byte that completes while `bufFull` is still set sets `rxOverflow`. The buffer keeps the older byte.
- R12: With `enable` low the port is inactive, and `bufFull`, `writeCollision` and `rxOverflow` are cleared.
- R13: After reset every status flag and output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port on |
| modeSel | input | 4 | Role and clock-source selection |
| clkIdleHigh | input | 1 | SCK idle level |
| clkPhase | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sampleLate | input | 1 | Master sample at end of data time |
| bufWrEn | input | 1 | Write strobe for the transmit byte |
| bufWrData | input | 8 | Transmit byte |
| bufRdEn | input | 1 | Read strobe, clears buffer-full |
| bufRdData | output | 8 | Received byte |
| bufFull | output | 1 | Unread byte in the buffer |
| writeCollision | output | 1 | Write attempted while busy |
| rxOverflow | output | 1 | Byte completed while the buffer was full |
| xferDone | output | 1 | One-cycle pulse per completed byte |
| timerPulse | input | 1 | External timer tick for master clock mode 3 |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOutEn | output | 1 | Drive enable for sckOut |
| sdiIn | input | 1 | Serial data in |
| sdoOut | output | 1 | Serial data out |
| sdoOutEn | output | 1 | Drive enable for sdoOut |
| ssN | input | 1 | Active-low slave select |

## Verification
The sample position is the hardest behaviour to reach from the ports. A loopback returns the same byte whichever half of the data time is sampled. The bench therefore feeds the data-in pin with the SCK level relative to its idle level. An early sample then reads all zeros or all ones, and a late sample reads the opposite value. A second hard case is releasing the select input partway through a byte. The bench plays the external master and clocks three bits before raising the select. After the select goes low again, a full byte must carry the reloaded transmit byte and receive cleanly.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BITS = 8;

  typedef enum logic [3:0] {
    MODE_M_FAST = 4'd0,
    MODE_M_MID  = 4'd1,
    MODE_M_SLOW = 4'd2,
    MODE_M_TMR  = 4'd3,
    MODE_S_SEL  = 4'd4,
    MODE_S_FREE = 4'd5
  } portMode_e;

  typedef struct packed {
    logic start;
    logic sample;
    logic shift;
    logic done;
    logic abort;
    logic sdiBit;
  } spiStrobe_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [3:0] mode,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       sampleLate,
  input  logic       bufWrEn,
  input  logic       timerPulse,
  input  logic       sckIn,
  input  logic       ssN,
  input  logic       sdiIn,
  output spiStrobe_t stb,
  output logic       busy,
  output logic       sckOut,
  output logic       sckOutEn,
  output logic       sdoOutEn
);
  localparam int CNT_W     = $clog2(DIV_SLOW / 2);
  localparam int HC_W      = $clog2(2 * BITS + 1);
  localparam int BC_W      = $clog2(BITS);
  localparam int LAST_HALF = 2 * BITS;

  logic isMaster, isSlave, ssUsed;
  assign isMaster = enable && (mode == MODE_M_FAST || mode == MODE_M_MID ||
                               mode == MODE_M_SLOW || mode == MODE_M_TMR);
  assign isSlave  = enable && (mode == MODE_S_SEL || mode == MODE_S_FREE);
  assign ssUsed   = (mode == MODE_S_SEL);

  // input synchronisers
  logic [SYNC_STAGES-1:0] sckSh, ssSh, sdiSh;
  logic sckDly, ssDly;
  logic sckSync, ssSync, sdiSync;
  assign sckSync = sckSh[SYNC_STAGES-1];
  assign ssSync  = ssSh[SYNC_STAGES-1];
  assign sdiSync = sdiSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh  <= '0;
      ssSh   <= '1;
      sdiSh  <= '0;
      sckDly <= 1'b0;
      ssDly  <= 1'b1;
    end else begin
      sckSh  <= {sckSh[SYNC_STAGES-2:0], sckIn};
      ssSh   <= {ssSh[SYNC_STAGES-2:0], ssN};
      sdiSh  <= {sdiSh[SYNC_STAGES-2:0], sdiIn};
      sckDly <= sckSync;
      ssDly  <= ssSync;
    end
  end

  // master clock generation
  logic             running, sckReg, tick, accept, mStart;
  logic [HC_W-1:0]  halfCnt, sOff, oOff;
  logic [CNT_W-1:0] divCnt, halfMax;
  logic             mSample, mShift, mDone;

  always_comb begin
    case (mode)
      MODE_M_MID:  halfMax = CNT_W'(DIV_MID / 2 - 1);
      MODE_M_SLOW: halfMax = CNT_W'(DIV_SLOW / 2 - 1);
      default:     halfMax = CNT_W'(DIV_FAST / 2 - 1);
    endcase
  end

  assign tick    = running && ((mode == MODE_M_TMR) ? timerPulse : (divCnt == halfMax));
  assign accept  = bufWrEn && !busy && (isMaster || isSlave);
  assign mStart  = accept && isMaster;
  assign sOff    = HC_W'(cpha) + HC_W'(sampleLate);
  assign oOff    = HC_W'(1) + HC_W'(cpha);
  assign mSample = tick && halfCnt >= sOff && halfCnt <= sOff + HC_W'(LAST_HALF - 2) &&
                   (halfCnt[0] == sOff[0]);
  assign mShift  = tick && halfCnt >= oOff && halfCnt <= oOff + HC_W'(LAST_HALF - 4) &&
                   (halfCnt[0] == oOff[0]);
  assign mDone   = tick && halfCnt == HC_W'(LAST_HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      halfCnt <= '0;
      divCnt  <= '0;
      sckReg  <= 1'b0;
    end else if (!isMaster) begin
      running <= 1'b0;
      halfCnt <= '0;
      divCnt  <= '0;
      sckReg  <= cpol;
    end else if (mStart) begin
      running <= 1'b1;
      halfCnt <= '0;
      divCnt  <= '0;
      sckReg  <= cpol;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        halfCnt <= halfCnt + 1'b1;
        if (halfCnt < HC_W'(LAST_HALF)) sckReg <= ~sckReg;
        else                            running <= 1'b0;
      end
    end else begin
      sckReg <= cpol;
    end
  end

  // slave edge tracking
  logic            sckRise, sckFall, leadEdge, trailEdge, ssActive, ssRose;
  logic            sSample, sShift, sDone, sAbort;
  logic [BC_W-1:0] bitCnt;

  assign sckRise   = sckSync && !sckDly;
  assign sckFall   = !sckSync && sckDly;
  assign leadEdge  = cpol ? sckFall : sckRise;
  assign trailEdge = cpol ? sckRise : sckFall;
  assign ssActive  = isSlave && (!ssUsed || !ssSync);
  assign ssRose    = ssSync && !ssDly;
  assign sSample   = ssActive && (cpha ? trailEdge : leadEdge);
  assign sShift    = ssActive && (cpha ? leadEdge : trailEdge) && (bitCnt != '0);
  assign sDone     = sSample && (bitCnt == BC_W'(BITS - 1));
  assign sAbort    = isSlave && ssUsed && ssRose;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     bitCnt <= '0;
    else if (!isSlave || (ssUsed && ssSync))       bitCnt <= '0;
    else if (sSample)                              bitCnt <= bitCnt + 1'b1;
  end

  assign busy     = running || (isSlave && bitCnt != '0);
  assign sckOut   = sckReg;
  assign sckOutEn = isMaster;
  assign sdoOutEn = isMaster || ssActive;

  always_comb begin
    stb.start  = accept;
    stb.sample = mSample || sSample;
    stb.shift  = mShift || sShift;
    stb.done   = mDone || sDone;
    stb.abort  = sAbort;
    stb.sdiBit = isMaster ? sdiIn : sdiSync;
  end

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && !running && $past(isMaster) && $past(rstN) && $stable(cpol) |-> sckReg == cpol);
  p_half_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> halfCnt <= HC_W'(LAST_HALF));
  p_deselect_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    isSlave && ssUsed && ssSync |=> bitCnt == '0);
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  spiStrobe_t      stb,
  input  logic            busy,
  input  logic            bufWrEn,
  input  logic [BITS-1:0] bufWrData,
  input  logic            bufRdEn,
  output logic [BITS-1:0] bufRdData,
  output logic            bufFull,
  output logic            writeCollision,
  output logic            rxOverflow,
  output logic            xferDone,
  output logic            sdoOut
);
  logic [BITS-1:0] txHold, txShift, rxShift, rxBuf, rxNext;

  assign rxNext = stb.sample ? {rxShift[BITS-2:0], stb.sdiBit} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold         <= '0;
      txShift        <= '0;
      rxShift        <= '0;
      rxBuf          <= '0;
      bufFull        <= 1'b0;
      writeCollision <= 1'b0;
      rxOverflow     <= 1'b0;
      xferDone       <= 1'b0;
    end else begin
      if (stb.start) begin
        txHold  <= bufWrData;
        txShift <= bufWrData;
      end else if (stb.abort) begin
        txShift <= txHold;
      end else if (stb.shift) begin
        txShift <= {txShift[BITS-2:0], 1'b0};
      end
      if (stb.sample) rxShift <= rxNext;
      xferDone <= stb.done;
      if (!enable) begin
        bufFull        <= 1'b0;
        writeCollision <= 1'b0;
        rxOverflow     <= 1'b0;
      end else begin
        if (bufWrEn && busy) writeCollision <= 1'b1;
        if (stb.done && bufFull && !bufRdEn) begin
          rxOverflow <= 1'b1;
        end else if (stb.done) begin
          rxBuf   <= rxNext;
          bufFull <= 1'b1;
        end else if (bufRdEn) begin
          bufFull <= 1'b0;
        end
      end
    end
  end

  assign bufRdData = rxBuf;
  assign sdoOut    = txShift[BITS-1];

  p_full_from_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(stb.done));
  p_collision_r10: assert property (@(posedge clk) disable iff (!rstN)
    enable && bufWrEn && busy |=> writeCollision || !enable);
  p_overflow_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    enable && stb.done && bufFull && !bufRdEn |=> rxOverflow && $stable(rxBuf));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [3:0] modeSel,
  input  logic       clkIdleHigh,
  input  logic       clkPhase,
  input  logic       sampleLate,
  input  logic       bufWrEn,
  input  logic [7:0] bufWrData,
  input  logic       bufRdEn,
  output logic [7:0] bufRdData,
  output logic       bufFull,
  output logic       writeCollision,
  output logic       rxOverflow,
  output logic       xferDone,
  input  logic       timerPulse,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOutEn,
  input  logic       sdiIn,
  output logic       sdoOut,
  output logic       sdoOutEn,
  input  logic       ssN
);
  spiStrobe_t stb;
  logic       busy;

  spi_port_ctrl #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(modeSel), .cpol(clkIdleHigh),
    .cpha(clkPhase), .sampleLate(sampleLate), .bufWrEn(bufWrEn), .timerPulse(timerPulse),
    .sckIn(sckIn), .ssN(ssN), .sdiIn(sdiIn), .stb(stb), .busy(busy), .sckOut(sckOut),
    .sckOutEn(sckOutEn), .sdoOutEn(sdoOutEn)
  );

  spi_port_dp i_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .stb(stb), .busy(busy), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .bufRdEn(bufRdEn), .bufRdData(bufRdData), .bufFull(bufFull),
    .writeCollision(writeCollision), .rxOverflow(rxOverflow), .xferDone(xferDone),
    .sdoOut(sdoOut)
  );
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 10;  // bench-master SCK half period in clocks

  typedef struct packed {
    logic [3:0]  mode;
    logic        cpol;
    logic        cpha;
    logic        late;
    logic        phaseSdi;
    logic [7:0]  tx;
    logic [7:0]  expRx;
    logic [15:0] expCycles;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 16'd35},
    '{4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 16'd137},
    '{4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h81, 16'd35},
    '{4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h5A, 16'd545},
    '{4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h00, 16'd35},
    '{4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 8'hFF, 16'd35},
    '{4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h12, 8'hFF, 16'd35},
    '{4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h12, 8'h00, 16'd35},
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3, 16'd0}
  };

  logic clk = 0, rstN = 0, enable = 0;
  logic [3:0] modeSel = 0;
  logic clkIdleHigh = 0, clkPhase = 0, sampleLate = 0;
  logic bufWrEn = 0, bufRdEn = 0;
  logic [7:0] bufWrData = 0;
  logic [7:0] bufRdData;
  logic bufFull, writeCollision, rxOverflow, xferDone;
  logic timerPulse = 0, sckIn = 0, ssN = 1, sdiDrv = 0;
  logic [1:0] sdiSel = 0;  // 0 loopback, 1 sck phase, 2 driven
  logic sckOut, sckOutEn, sdoOut, sdoOutEn, sdiIn;
  int   tests = 0, fails = 0;

  assign sdiIn = (sdiSel == 2'd0) ? sdoOut : (sdiSel == 2'd1) ? (sckOut ^ clkIdleHigh) : sdiDrv;

  spi_port i_spi_port (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel), .clkIdleHigh(clkIdleHigh),
    .clkPhase(clkPhase), .sampleLate(sampleLate), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .bufRdEn(bufRdEn), .bufRdData(bufRdData), .bufFull(bufFull),
    .writeCollision(writeCollision), .rxOverflow(rxOverflow), .xferDone(xferDone),
    .timerPulse(timerPulse), .sckIn(sckIn), .sckOut(sckOut), .sckOutEn(sckOutEn),
    .sdiIn(sdiIn), .sdoOut(sdoOut), .sdoOutEn(sdoOutEn), .ssN(ssN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : timer_gen
    forever begin
      repeat (2) @(negedge clk);
      timerPulse = 1;
      @(negedge clk);
      timerPulse = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    bufWrData = d;
    bufWrEn = 1;
    @(negedge clk);
    bufWrEn = 0;
  endtask

  task automatic cpuRead();
    bufRdEn = 1;
    @(negedge clk);
    bufRdEn = 0;
  endtask

  // master write followed by count of negedges until bufFull
  task automatic masterRun(input logic [7:0] d, output int n);
    bufWrData = d;
    bufWrEn = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      bufWrEn = 0;
    end while (!bufFull && n < 3000);
  endtask

  // bench acts as external master driving nbits
  task automatic slaveBits(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
    miso = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!clkPhase) begin
        sdiDrv = mosi[i];
        waitCycles(SH);
        miso[i] = sdoOut;
        sckIn = ~clkIdleHigh;
        waitCycles(SH);
        sckIn = clkIdleHigh;
      end else begin
        sckIn = ~clkIdleHigh;
        sdiDrv = mosi[i];
        waitCycles(SH);
        miso[i] = sdoOut;
        sckIn = clkIdleHigh;
        waitCycles(SH);
      end
    end
    waitCycles(SH);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    logic [7:0] miso;
    waitCycles(4);
    rstN = 1;
    waitCycles(1);
    // R13 reset state
    check(!bufFull && !writeCollision && !rxOverflow && !xferDone, "R13 flags", 
          {bufFull, writeCollision, rxOverflow, xferDone}, 0);
    check(!sckOutEn && !sdoOutEn, "R13 enables", {sckOutEn, sdoOutEn}, 0);

    // master vector table: R1 R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      modeSel = VECS[v].mode;
      clkIdleHigh = VECS[v].cpol;
      clkPhase = VECS[v].cpha;
      sampleLate = VECS[v].late;
      sdiSel = VECS[v].phaseSdi ? 2'd1 : 2'd0;
      enable = 1;
      waitCycles(3);
      check(sckOut == VECS[v].cpol, "R4 idle level before", sckOut, VECS[v].cpol);
      masterRun(VECS[v].tx, n);
      check(bufFull && xferDone, "R9 full and done pulse", {bufFull, xferDone}, 3);
      if (VECS[v].expCycles != 0)
        check(n == int'(VECS[v].expCycles), "R3 R2 transfer length", n, VECS[v].expCycles);
      check(bufRdData == VECS[v].expRx, VECS[v].phaseSdi ? "R5 sample position" : "R1 byte exchange",
            bufRdData, VECS[v].expRx);
      check(sckOut == VECS[v].cpol, "R4 idle level after", sckOut, VECS[v].cpol);
      cpuRead();
      check(!bufFull, "R9 read clears full", bufFull, 0);
    end

    // R10 collision, data ignored
    modeSel = 4'd1; clkIdleHigh = 0; clkPhase = 0; sampleLate = 0; sdiSel = 0;
    waitCycles(3);
    cpuWrite(8'h66);
    waitCycles(5);
    masterRun(8'h99, n);
    check(writeCollision, "R10 collision flag", writeCollision, 1);
    check(bufRdData == 8'h66, "R10 write ignored", bufRdData, 8'h66);
    cpuRead();

    // R12 disable clears flags
    enable = 0;
    waitCycles(2);
    check(!writeCollision && !sckOutEn, "R12 disable clears", {writeCollision, sckOutEn}, 0);

    // R2 invalid mode inactive
    enable = 1; modeSel = 4'hF;
    waitCycles(2);
    cpuWrite(8'h11);
    waitCycles(60);
    check(!bufFull && !sckOutEn && !sdoOutEn, "R2 invalid mode", {bufFull, sckOutEn, sdoOutEn}, 0);

    // slave with select
    modeSel = 4'd4; clkIdleHigh = 0; clkPhase = 0; sdiSel = 2; sckIn = 0; ssN = 1;
    waitCycles(6);
    check(!sdoOutEn, "R7 deselected tristate", sdoOutEn, 0);
    cpuWrite(8'hA5);
    ssN = 0;
    waitCycles(4);
    slaveBits(8'h3C, 8, miso);
    check(miso == 8'hA5, "R6 slave transmit", miso, 8'hA5);
    check(bufFull && bufRdData == 8'h3C, "R1 slave receive", bufRdData, 8'h3C);
    cpuWrite(8'h0F);
    slaveBits(8'h77, 8, miso);
    check(rxOverflow, "R11 overflow flag", rxOverflow, 1);
    check(bufRdData == 8'h3C, "R11 old byte kept", bufRdData, 8'h3C);
    cpuRead();

    // R7 mid-byte release, other clock mode
    ssN = 1;
    waitCycles(4);
    clkIdleHigh = 1; clkPhase = 1; sckIn = 1;
    waitCycles(6);
    cpuWrite(8'hC6);
    ssN = 0;
    waitCycles(4);
    slaveBits(8'hFF, 3, miso);
    ssN = 1;
    waitCycles(6);
    check(!sdoOutEn, "R7 release tristate", sdoOutEn, 0);
    ssN = 0;
    waitCycles(4);
    slaveBits(8'h81, 8, miso);
    check(miso == 8'hC6, "R7 tx reloaded", miso, 8'hC6);
    check(bufFull && bufRdData == 8'h81, "R7 count restarted", bufRdData, 8'h81);
    cpuRead();

    // R8 select ignored
    ssN = 1;
    waitCycles(4);
    modeSel = 4'd5; clkIdleHigh = 0; clkPhase = 0; sckIn = 0;
    waitCycles(6);
    check(sdoOutEn, "R8 drive with ssN high", sdoOutEn, 1);
    cpuWrite(8'hE7);
    slaveBits(8'h24, 8, miso);
    check(miso == 8'hE7, "R8 slave transmit", miso, 8'hE7);
    check(bufFull && bufRdData == 8'h24, "R8 slave receive", bufRdData, 8'h24);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule